// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and verifies the even-parity bit of a PCI-style bus for an agent that can act either as initiator or as target. It watches the frame, initiator-ready and target-ready strobes, the multiplexed 32-bit address/data lines and the 4-bit command/byte-enable lines. A role input tells it which side of the current transfer it is on. From these it works out when it must drive the parity line, what value to drive, and whether the parity seen on the bus after a phase it received is correct.

Parity is always launched one clock after the phase it covers. When a received data phase carries bad parity, the data-parity error line is pulled low two clocks after that phase. Address parity errors, and data parity errors on broadcast special cycles, are reported on the system-error line as a single-clock low pulse. The system-error line is driven only low or released. The transaction state machines, arbitration and configuration registers of a full interface sit outside this block and feed it only the strobes, the role and two enables.

Top module: `pci_parity_unit`

## Requirements
- R1: While `rst_n` is low, `par_oe`, `perr_oe` and `serr_oe` are 0, and asserting `rst_n` low forces them to 0 at once without waiting for a clock edge.
- R2: Whenever `par_oe` is 1, `par_out` makes the XOR of the 36 bits `ad` and `cbe_n`, taken in the cycle before, together with `par_out`, equal to 0 (even parity).
- R3: With `is_master`=1, `par_oe` is 1 in the cycle after an address phase and in the cycle after each completed write data phase, and 0 otherwise.
- R4: With `is_master`=0, `par_oe` is 1 only in the cycle after each completed read data phase.
- R5: An address phase is a cycle with `frame_n`=0 that follows a cycle with `frame_n`=1 and `irdy_n`=1. A data phase completes only in a cycle inside a transfer where `irdy_n`=0 and `trdy_n`=0. Wait cycles, in which either strobe is 1, cause no parity drive and no check.
- R6: The receiver of a data phase checks it: the target on writes, the master on reads. If `par_in` in the cycle after the phase differs from the even parity of that phase, `perr_n_out`=0 with `perr_oe`=1 in the second cycle after the phase, for one cycle. `perr_oe` then stays 1 with `perr_n_out`=1 for one more cycle.
- R7: When `perr_resp_en` is 0 in the cycle that `par_in` is compared, no data parity error is driven on the error line.
- R8: For the special-cycle command `cbe_n`=4'b0001 in the address phase, a data parity error never drives `perr_oe`. With `serr_en`=1 it pulses `serr_oe` instead, in the same cycle that the error line would have been driven.
- R9: With `is_master`=0, an address phase whose parity is wrong in the following cycle's `par_in` sets `serr_oe`=1 for exactly one cycle, two cycles after the address phase. As master, no address parity error is reported. A report that would fall in the cycle right after a pulse is dropped.
- R10: When `serr_en` is 0 in the cycle that `par_in` is compared, `serr_oe` stays 0.
- R11: Bit 0 of the command captured in the address phase selects the direction: 1 is a write and 0 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released through a synchronizer |
| is_master | input | 1 | 1 when this agent is the initiator of the current transfer, 0 when it is the target |
| frame_n | input | 1 | Sampled frame strobe, active low |
| irdy_n | input | 1 | Sampled initiator-ready strobe, active low |
| trdy_n | input | 1 | Sampled target-ready strobe, active low |
| ad | input | 32 | Sampled address/data lines |
| cbe_n | input | 4 | Sampled command (address phase) or byte enables (data phase) |
| par_in | input | 1 | Sampled parity line |
| perr_resp_en | input | 1 | Enables reporting of data parity errors |
| serr_en | input | 1 | Enables reporting on the system-error line |
| par_out | output | 1 | Parity value to drive |
| par_oe | output | 1 | Output enable for the parity line |
| perr_n_out | output | 1 | Value for the data-parity error line, active low |
| perr_oe | output | 1 | Output enable for the data-parity error line |
| serr_oe | output | 1 | When 1 the system-error line is pulled low, otherwise released |

## Verification
On every cycle the assertions check the drive that must follow a master's address phase and the absence of drive after a target's write phase. They also check that an error-line pulse always traces back to a completed phase two cycles before and never to a special cycle, that the two enables block their outputs, and that a system-error pulse lasts one cycle. The exact parity value, the choice of which side checks on reads and writes, the effect of wait cycles, the suppression of a back-to-back system-error report and the asynchronous clear in mid-transfer come out only from the bench's scenarios. Those scenarios are random and directed transfers compared against a cycle model written from the requirements.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  localparam int CMD_W = 4;

  // Broadcast command that carries no target response
  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;

  // Command bit 0 separates writes (1) from reads (0)
  function automatic logic cmd_is_write(input logic [CMD_W-1:0] cmd);
    return cmd[0];
  endfunction

  function automatic logic cmd_is_special(input logic [CMD_W-1:0] cmd);
    return cmd == CMD_SPECIAL;
  endfunction

endpackage

// File: rtl/pci_rst_sync.sv
module pci_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pci_phase_track.sv
module pci_phase_track
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [CMD_W-1:0] cmd_n,
  output logic             addr_ph,
  output logic             data_done,
  output logic             is_write,
  output logic             is_special
);

  logic             frame_q, irdy_q, in_txn_q;
  logic             frame_d, irdy_d, in_txn_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;

  // R5: address phase starts from an idle bus; completion needs both ready
  always_comb begin
    addr_ph   = !frame_n && frame_q && irdy_q;
    data_done = in_txn_q && !irdy_n && !trdy_n;
    frame_d   = frame_n;
    irdy_d    = irdy_n;
    cmd_d     = addr_ph ? cmd_n : cmd_q;
    in_txn_d  = in_txn_q;
    if (addr_ph)                   in_txn_d = 1'b1;
    else if (data_done && frame_n) in_txn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b1;
      irdy_q   <= 1'b1;
      in_txn_q <= 1'b0;
      cmd_q    <= '0;
    end else begin
      frame_q  <= frame_d;
      irdy_q   <= irdy_d;
      in_txn_q <= in_txn_d;
      cmd_q    <= cmd_d;
    end
  end

  // R11: direction from the captured command
  assign is_write   = cmd_is_write(cmd_q);
  assign is_special = cmd_is_special(cmd_q);

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            addr_ph,
  input  logic            data_done,
  input  logic            is_write,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  output logic            par_q,
  output logic            par_oe_q
);

  logic par_calc, load_en, par_d, drive_d;

  always_comb begin
    par_calc = ^{ad, cbe_n};
    load_en  = addr_ph || data_done;
    par_d    = load_en ? par_calc : par_q;
    // R3 master: address and write data; R4 target: read data
    if (is_master) drive_d = addr_ph || (data_done && is_write);
    else           drive_d = data_done && !is_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_q    <= par_d;
      par_oe_q <= drive_d;
    end
  end

  p_master_addr_par_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && addr_ph) |=> par_oe_q);

  p_target_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !addr_ph && data_done && is_write) |=> !par_oe_q);

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic addr_ph,
  input  logic data_done,
  input  logic is_write,
  input  logic is_special,
  input  logic par_in,
  input  logic par_exp,
  input  logic perr_resp_en,
  input  logic serr_en,
  output logic perr_act,
  output logic perr_hold,
  output logic serr_act
);

  logic chk_d_q, chk_sc_q, chk_a_q;
  logic rx_phase, mism;
  logic chk_d_d, chk_sc_d, chk_a_d, perr_d, serr_d;

  always_comb begin
    // R6: receiver is the target on writes, the master on reads
    rx_phase = data_done && (is_master ? !is_write : is_write);
    chk_d_d  = rx_phase;
    chk_sc_d = rx_phase && is_special;
    chk_a_d  = addr_ph && !is_master;          // R9
    mism     = par_in ^ par_exp;
    perr_d   = chk_d_q && !chk_sc_q && mism && perr_resp_en;      // R6 R7 R8
    serr_d   = serr_en && mism && (chk_a_q || chk_sc_q) && !serr_act; // R9 R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_d_q   <= 1'b0;
      chk_sc_q  <= 1'b0;
      chk_a_q   <= 1'b0;
      perr_act  <= 1'b0;
      perr_hold <= 1'b0;
      serr_act  <= 1'b0;
    end else begin
      chk_d_q   <= chk_d_d;
      chk_sc_q  <= chk_sc_d;
      chk_a_q   <= chk_a_d;
      perr_act  <= perr_d;
      perr_hold <= perr_act;
      serr_act  <= serr_d;
    end
  end

  p_perr_after_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    perr_act |-> $past(data_done, 2));

  p_perr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_resp_en |=> !perr_act);

  p_special_no_perr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_act |-> !$past(is_special, 2));

  p_serr_one_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_act |=> !serr_act);

  p_serr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_en |=> !serr_act);

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int BE_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par_in,
  input  logic            perr_resp_en,
  input  logic            serr_en,
  output logic            par_out,
  output logic            par_oe,
  output logic            perr_n_out,
  output logic            perr_oe,
  output logic            serr_oe
);

  logic rst_sync_n;
  logic addr_ph, data_done, is_write, is_special;
  logic par_q, par_oe_q;
  logic perr_act, perr_hold, serr_act;

  pci_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pci_phase_track u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .cmd_n      (cbe_n[CMD_W-1:0]),
    .addr_ph    (addr_ph),
    .data_done  (data_done),
    .is_write   (is_write),
    .is_special (is_special)
  );

  pci_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .is_master (is_master),
    .addr_ph   (addr_ph),
    .data_done (data_done),
    .is_write  (is_write),
    .ad        (ad),
    .cbe_n     (cbe_n),
    .par_q     (par_q),
    .par_oe_q  (par_oe_q)
  );

  pci_par_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .is_master    (is_master),
    .addr_ph      (addr_ph),
    .data_done    (data_done),
    .is_write     (is_write),
    .is_special   (is_special),
    .par_in       (par_in),
    .par_exp      (par_q),
    .perr_resp_en (perr_resp_en),
    .serr_en      (serr_en),
    .perr_act     (perr_act),
    .perr_hold    (perr_hold),
    .serr_act     (serr_act)
  );

  assign par_out    = par_q;
  assign par_oe     = par_oe_q;
  assign perr_n_out = !perr_act;
  assign perr_oe    = perr_act || perr_hold;
  assign serr_oe    = serr_act;

endmodule

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        is_master, frame_n, irdy_n, trdy_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        par_in, perr_resp_en, serr_en;
  logic        par_out, par_oe, perr_n_out, perr_oe, serr_oe;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model state
  bit wr, sp;
  bit pend_bad, last_par;
  bit p_rx, p_sp, p_a;
  bit e_paroe, e_par, e_perr, e_perr_oe, e_serr;
  string ptag = "R6";
  string stag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .par_in(par_in),
    .perr_resp_en(perr_resp_en), .serr_en(serr_en), .par_out(par_out),
    .par_oe(par_oe), .perr_n_out(perr_n_out), .perr_oe(perr_oe), .serr_oe(serr_oe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit even_par(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic clear_model();
    pend_bad = 0; last_par = 0; p_rx = 0; p_sp = 0; p_a = 0;
    e_paroe = 0; e_par = 0; e_perr = 0; e_perr_oe = 0; e_serr = 0;
  endtask

  // One bus cycle: apply at negedge, predict, advance, compare.
  task automatic cyc(input logic f, input logic i, input logic t, input logic [3:0] c,
                     input bit corrupt, input bit is_addr, input bit is_done, input string tag);
    logic [31:0] a;
    bit n_perr, n_serr, n_paroe, n_par;
    a = $urandom();
    frame_n = f; irdy_n = i; trdy_n = t; ad = a; cbe_n = c;
    par_in  = last_par ^ pend_bad;
    n_perr  = p_rx && pend_bad && perr_resp_en && !p_sp;
    ptag    = !perr_resp_en ? "R7" : (p_sp ? "R8" : "R6");
    n_serr  = serr_en && pend_bad && (p_a || p_sp) && !e_serr;
    stag    = !serr_en ? "R10" : (p_sp ? "R8" : "R9");
    n_paroe = is_master ? (is_addr || (is_done && wr)) : (is_done && !wr);
    n_par   = even_par(a, c);
    p_rx    = is_done && (is_master ? !wr : wr);
    p_sp    = p_rx && sp;
    p_a     = is_addr && !is_master;
    pend_bad = corrupt;
    last_par = n_par;
    e_perr_oe = n_perr || e_perr;
    e_perr  = n_perr;
    e_serr  = n_serr;
    e_paroe = n_paroe;
    e_par   = n_par;
    @(posedge clk);
    @(negedge clk);
    check(tag, "par_oe", par_oe, e_paroe);
    if (e_paroe) check("R2", "par_out", par_out, e_par);
    check(ptag, "perr_oe", perr_oe, e_perr_oe);
    if (e_perr_oe) check(ptag, "perr_n_out", perr_n_out, !e_perr);
    check(stag, "serr_oe", serr_oe, e_serr);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1, 1, 1, 4'($urandom()), 0, 0, 0, "R5");
  endtask

  task automatic txn(input bit role, input logic [3:0] cmd, input int nph, input bit bad_a,
                     input int bad_mask, input bit pe, input bit se, input string dtag);
    string atag;
    string ctag;
    is_master = role; perr_resp_en = pe; serr_en = se;
    wr = cmd[0]; sp = (cmd == 4'b0001);
    atag = role ? "R3" : "R4";
    ctag = (dtag != "") ? dtag : atag;
    cyc(0, 1, 1, cmd, bad_a, 1, 0, atag);
    for (int p = 0; p < nph; p++) begin
      int w;
      w = $urandom_range(0, 2);
      for (int k = 0; k < w; k++) begin
        int m;
        m = $urandom_range(0, 2);
        cyc(0, (m != 2), (m != 1), 4'($urandom()), 0, 0, 0, "R5");
      end
      cyc((p == nph - 1), 0, 0, 4'($urandom()), bad_mask[p], 0, 1, ctag);
    end
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 0; is_master = 0; frame_n = 1; irdy_n = 1; trdy_n = 1;
    ad = '0; cbe_n = '0; par_in = 0; perr_resp_en = 1; serr_en = 1;
    clear_model();
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    check("R1", "par_oe reset", par_oe, 1'b0);
    check("R1", "perr_oe reset", perr_oe, 1'b0);
    check("R1", "serr_oe reset", serr_oe, 1'b0);
    rst_n = 1;
    idle(4);

    // R3 R11: master write (cmd 0111) drives parity after address and data
    txn(1, 4'b0111, 3, 0, 0, 1, 1, "R11");
    // R11: master read (cmd 0110) drives after address only; R6 checks read data
    txn(1, 4'b0110, 3, 0, 'b010, 1, 1, "R11");
    // R4: target read drives after each data phase
    txn(0, 4'b0110, 2, 0, 0, 1, 1, "");
    // R6: target write with errors on two phases
    txn(0, 4'b0111, 3, 0, 'b101, 1, 1, "");
    // R7: same errors with response disabled
    txn(0, 4'b0111, 2, 0, 'b11, 0, 1, "");
    // R9: target address error; R10 gated; master does not check
    txn(0, 4'b0011, 1, 1, 0, 1, 1, "");
    txn(0, 4'b0011, 1, 1, 0, 1, 0, "");
    txn(1, 4'b0011, 1, 1, 0, 1, 1, "");
    // R8: special cycle data error goes to system-error line
    txn(0, 4'b0001, 1, 0, 'b1, 1, 1, "");
    // R8 R9: address and special data errors back to back, second dropped
    txn(0, 4'b0001, 2, 1, 'b11, 1, 1, "");

    // R1: asynchronous clear in mid-transfer
    is_master = 1; wr = 1; sp = 0;
    cyc(0, 1, 1, 4'b0111, 0, 1, 0, "R3");
    #1 rst_n = 0;
    #1 check("R1", "par_oe async", par_oe, 1'b0);
    check("R1", "perr_oe async", perr_oe, 1'b0);
    check("R1", "serr_oe async", serr_oe, 1'b0);
    frame_n = 1; irdy_n = 1; trdy_n = 1;
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(4);

    for (int n = 0; n < 80; n++) begin
      txn($urandom_range(0, 1), 4'($urandom()), $urandom_range(1, 4),
          ($urandom_range(0, 3) == 0), int'($urandom_range(0, 15)) & int'($urandom_range(0, 15)),
          ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0), "");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule